// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a write-only configuration port for a larger device. A host drives three wires: an active-low chip select, a serial clock and a data line. While chip select is low, the block shifts in one word per frame, most significant bit first. When chip select returns high, the data field of the word is copied into one of eight control registers, chosen by the address field carried at the end of the word. All register contents are presented in parallel on one flat output bus, so that the rest of the chip can use them directly.

The three serial wires and an external active-low shutdown pin are brought into the system clock domain through multi-stage synchronizers. Edges of the serial clock and of chip select are detected in that domain. A frame is accepted only if exactly one full word was clocked in and the address names a register that exists. Anything else leaves every register unchanged. The block also drives a combined power-down output. That output is set when the shutdown bit of the operating-control register is clear, or when the external pin is held low. Programming continues to work while the device is powered down.

Top module: `sbank_top`

## Requirements
- R1: A frame is 24 bits sent MSB first: word bits [23:4] are the register data and bits [3:0] are the address. A frame that is accepted writes exactly those 20 data bits into the addressed register.
- R2: Serial clock rising edges that occur while chip select is high shift nothing, and they do not disturb the frame that follows.
- R3: Registers change only when chip select rises. A complete word held with chip select still low leaves every register unchanged.
- R4: Addresses 0 to 7 select, in order: RF main divider, RF reference divider, IF main divider, IF reference divider, operating control, configuration, current control and test. Register n appears at regs_o[20*n+19 : 20*n].
- R5: A frame whose address is 8 to 15 is discarded, and no register changes.
- R6: A frame in which chip select rises after any number of serial clock rising edges other than 24 (for example 23 or 25) is discarded, and no register changes.
- R7: pdown_o is 1 when bit 0 of the operating-control register (address 4) is 0, or when shdn_n_i is low. Otherwise pdown_o is 0.
- R8: While pdown_o is 1, frames are still accepted, and the contents of all registers are retained.
- R9: Reset loads these values: 1 into each of the four divider registers, 0x00010 into the configuration register, and 0 into the others. The operating-control shutdown bit is therefore 0, and the device starts powered down.
- R10: Bits 19:1 of the operating-control register are stored as written but have no influence on pdown_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| csn_i | input | 1 | Active-low chip select, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| shdn_n_i | input | 1 | External active-low shutdown pin |
| regs_o | output | 160 | All eight registers, register n in bits 20n+19 down to 20n |
| pdown_o | output | 1 | Combined power-down indication |

## Verification
The bench builds the block with its default parameters: 20 data bits, a 4-bit address, eight registers and two synchronizer stages. With a 4-bit address, codes 8 to 15 can be sent, so the unmapped half of the address space can be exercised. The serial clock is run at one eighth of the system clock, which keeps every wire edge visible through the two-stage synchronizer. Random frames mix valid lengths with 23-bit and 25-bit ones and cover the full address range. They run both with the shutdown pin high and with it low. Directed cases cover clock edges sent while chip select is high, and a complete word held with chip select still low.

// File: rtl/sbank_pkg.sv
package sbank_pkg;

    localparam int DATA_W_DEF   = 20;
    localparam int ADDR_W_DEF   = 4;
    localparam int NUM_REGS_DEF = 8;
    localparam int SYNC_DEF     = 2;

    // register slot numbers (address codes)
    localparam int SLOT_RF_MAIN = 0;
    localparam int SLOT_RF_REF  = 1;
    localparam int SLOT_IF_MAIN = 2;
    localparam int SLOT_IF_REF  = 3;
    localparam int SLOT_OPCTRL  = 4;
    localparam int SLOT_CONFIG  = 5;
    localparam int SLOT_CURRENT = 6;
    localparam int SLOT_TEST    = 7;

    localparam int RUN_BIT = 0;   // 1 = operate, 0 = shut down

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_DROP  = 2'd2
    } rx_state_e;

    function automatic logic [31:0] slot_default(input int slot);
        logic [31:0] v;
        case (slot)
            SLOT_RF_MAIN, SLOT_RF_REF,
            SLOT_IF_MAIN, SLOT_IF_REF: v = 32'd1;
            SLOT_CONFIG:               v = 32'h0001_0;
            default:                   v = 32'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sbank_sync.sv
module sbank_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= RST_VAL;
                    else     stg[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= RST_VAL;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sbank_frame_rx.sv
module sbank_frame_rx
    import sbank_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    output logic              frm_vld,
    output logic [ADDR_W-1:0] frm_addr,
    output logic [DATA_W-1:0] frm_data
);
    localparam int FRAME_W = DATA_W + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic              sclk_d, csn_d;
    logic              sclk_rise, cs_rise, cs_fall;
    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;
    rx_state_e         st_q;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign cs_rise   = csn_s & ~csn_d;
    assign cs_fall   = ~csn_s & csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RX_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (cs_rise) begin
            st_q <= RX_IDLE;
        end else begin
            case (st_q)
                RX_IDLE: begin
                    if (cs_fall) begin
                        st_q  <= RX_SHIFT;
                        cnt_q <= '0;
                    end
                end
                RX_SHIFT: begin
                    if (sclk_rise) begin
                        if (cnt_q == FULL) begin
                            st_q <= RX_DROP;
                        end else begin
                            shift_q <= {shift_q[FRAME_W-2:0], sdi_s};
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_vld  <= 1'b0;
            frm_addr <= '0;
            frm_data <= '0;
        end else begin
            frm_vld  <= cs_rise && (st_q == RX_SHIFT) && (cnt_q == FULL);
            frm_addr <= shift_q[ADDR_W-1:0];
            frm_data <= shift_q[FRAME_W-1:ADDR_W];
        end
    end

    // R2
    cs_high_noshift_chk: assert property (@(posedge clk) disable iff (rst)
        csn_d |=> $stable(shift_q));

    // R6
    short_long_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && (st_q != RX_SHIFT || cnt_q != FULL)) |=> !frm_vld);

    // R3
    vld_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_rise |=> !frm_vld);
endmodule

// File: rtl/sbank_regs.sv
module sbank_regs
    import sbank_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam logic [DATA_W-1:0] RVAL = DATA_W'(slot_default(g));
            logic [DATA_W-1:0] val_q;
            always_ff @(posedge clk) begin
                if (rst)
                    val_q <= RVAL;
                else if (wr_en && (wr_addr == ADDR_W'(g)))
                    val_q <= wr_data;
            end
            assign regs_o[g*DATA_W +: DATA_W] = val_q;
        end
    endgenerate

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_o));

    // R5
    unmapped_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ({1'b0, wr_addr} >= (ADDR_W+1)'(NUM_REGS))) |=> $stable(regs_o));

    // R1
    opctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(SLOT_OPCTRL))
            |=> regs_o[SLOT_OPCTRL*DATA_W +: DATA_W] == $past(wr_data));
endmodule

// File: rtl/sbank_top.sv
module sbank_top
    import sbank_pkg::*;
#(
    parameter int DATA_W      = DATA_W_DEF,
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int NUM_REGS    = NUM_REGS_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sclk_i,
    input  logic                       csn_i,
    input  logic                       sdi_i,
    input  logic                       shdn_n_i,
    output logic [NUM_REGS*DATA_W-1:0] regs_o,
    output logic                       pdown_o
);
    localparam logic [3:0] SYNC_RST = 4'b1010;  // {pin, sdi, csn, sclk}

    logic [3:0]        raw, synced;
    logic              sclk_s, csn_s, sdi_s, pin_s;
    logic              frm_vld;
    logic [ADDR_W-1:0] frm_addr;
    logic [DATA_W-1:0] frm_data;
    logic              run_bit;

    assign raw = {shdn_n_i, sdi_i, csn_i, sclk_i};

    sbank_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (synced)
    );

    assign sclk_s = synced[0];
    assign csn_s  = synced[1];
    assign sdi_s  = synced[2];
    assign pin_s  = synced[3];

    sbank_frame_rx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (sclk_s),
        .csn_s    (csn_s),
        .sdi_s    (sdi_s),
        .frm_vld  (frm_vld),
        .frm_addr (frm_addr),
        .frm_data (frm_data)
    );

    sbank_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (frm_vld),
        .wr_addr (frm_addr),
        .wr_data (frm_data),
        .regs_o  (regs_o)
    );

    assign run_bit = regs_o[SLOT_OPCTRL*DATA_W + RUN_BIT];
    assign pdown_o = ~run_bit | ~pin_s;

    // R7
    pin_forces_pdown_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_s |-> pdown_o);

    // R7
    clear_run_pdown_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && frm_addr == ADDR_W'(SLOT_OPCTRL) && !frm_data[RUN_BIT]) |=> pdown_o);

    // R8
    write_in_shdn_chk: assert property (@(posedge clk) disable iff (rst)
        (!pin_s && frm_vld && frm_addr == '0) |=> regs_o[DATA_W-1:0] == $past(frm_data));
endmodule

// File: tb/sim_sbank_top.sv
module sim_sbank_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int DW = 20;
    localparam int NR = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, pin_n = 1'b1;
    logic [NR*DW-1:0] regs;
    logic pdown;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] model [NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    sbank_top u0 (
        .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
        .shdn_n_i(pin_n), .regs_o(regs), .pdown_o(pdown)
    );

    function automatic logic [DW-1:0] reset_val(input int n);
        if (n < 4) return 20'd1;
        if (n == 5) return 20'h00010;
        return 20'd0;
    endfunction

    function automatic logic exp_pdown();
        return !model[4][0] || !pin_n;
    endfunction

    function automatic logic [NR*DW-1:0] packed_model();
        logic [NR*DW-1:0] p;
        for (int i = 0; i < NR; i++) p[i*DW +: DW] = model[i];
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [NR*DW-1:0] act,
                       input logic [NR*DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(regs === packed_model(), req, regs, packed_model());
        chk(pdown === exp_pdown(), {req, " pdown"}, {159'd0, pdown}, {159'd0, exp_pdown()});
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        sdi = b;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic shift_only(input logic [31:0] w, input int n);
        csn = 1'b0;
        wait_clk(HALF);
        for (int i = n - 1; i >= 0; i--) sbit(w[i]);
        wait_clk(HALF);
    endtask

    task automatic finish_frame(input logic [31:0] w, input int n);
        csn = 1'b1;
        wait_clk(10);
        if (n == 24 && w[3:0] < 4'd8) model[w[3:0]] = w[23:4];
    endtask

    task automatic send(input logic [31:0] w, input int n);
        shift_only(w, n);
        finish_frame(w, n);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NR; i++) model[i] = reset_val(i);
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);

        // R9 reset contents and power-down state
        check_all("R9");

        // R1 / R4: write every register once with distinct data
        for (int i = 0; i < NR; i++) send({20'hA5000 + 20'(i * 20'h111), 4'(i)}, 24);
        check_all("R1 R4");

        // R7 / R10: run bit controls pdown, upper bits ignored
        send({20'hFFFFE, 4'd4}, 24);
        check_all("R10 run=0");
        send({20'h00001, 4'd4}, 24);
        check_all("R7 run=1");
        send({20'h5A5A1, 4'd4}, 24);
        check_all("R10 run=1 upper");

        // R7 / R8: pin low forces pdown, writes still accepted
        pin_n = 1'b0;
        wait_clk(6);
        check_all("R7 pin low");
        send({20'h12345, 4'd0}, 24);
        send({20'h6789A, 4'd7}, 24);
        check_all("R8 write in shdn");
        pin_n = 1'b1;
        wait_clk(6);
        check_all("R8 retained");

        // R2: clock edges while chip select high
        for (int i = 0; i < 9; i++) sbit(1'($urandom));
        wait_clk(6);
        check_all("R2 idle clocks");
        send({20'hC3C3C, 4'd2}, 24);
        check_all("R2 next frame");

        // R3: full word with chip select still low
        shift_only({20'hDEAD0, 4'd3}, 24);
        wait_clk(10);
        check_all("R3 before rise");
        finish_frame({20'hDEAD0, 4'd3}, 24);
        check_all("R3 after rise");

        // R5: unmapped addresses
        send({20'hFFFFF, 4'd8}, 24);
        send({20'h00000, 4'd15}, 24);
        check_all("R5 unmapped");

        // R6: wrong lengths
        send({8'h00, 20'h11111, 4'd1}, 23);
        send({7'h00, 1'b1, 20'h22222, 4'd1}, 25);
        check_all("R6 bad length");

        // random mix (R1 R5 R6 R7 R8)
        for (int k = 0; k < 120; k++) begin
            int unsigned r;
            int n;
            logic [31:0] w;
            r = $urandom % 10;
            n = (r == 0) ? 23 : (r == 1) ? 25 : 24;
            w = $urandom;
            if ((k % 20) == 10) pin_n = ~pin_n;
            send(w, n);
            check_all("R1 R5 R6 random");
        end
        pin_n = 1'b1;
        wait_clk(6);
        check_all("R7 final");

        summary();
    end
endmodule